// File: doc/BRIEF.md
# Audio Record and Playback Controller

This block moves audio samples between a pair of converters and a single-port sample memory. In record mode it captures one sample per cycle from an analog-to-digital converter and writes it to consecutive memory words, starting at word zero. In play mode it reads the same words back in order and hands each one to a digital-to-analog converter.

One address register serves both modes. The converter input buffer and the memory share a single tri-stated data bus. In record mode the buffer drives the bus and the memory takes the value. In play mode the buffer is released and the memory drives the bus. A read takes one cycle to return its data, so in play mode the output converter is strobed one cycle after the read is issued. This gives two cycles per played sample. A small top-level sequencer waits in idle and accepts a record or play request. It runs the selected pass over the whole memory and signals completion with a single-cycle pulse.

The behavioural memory (2^ADDR_W words of DATA_W bits) sits inside the block. Samples are SAMPLE_W bits wide and occupy the low bits of each word.

Top module: `audio_recorder`

## Requirements
- R1: A synchronous active-high reset, applied at any time, returns the controller to idle. In idle, adc_ld, adc_drive, dac_ld, done, mem_en and mem_rw are all 0.
- R2: In every record cycle, adc_ld, adc_drive, mem_en and mem_rw are all 1 and dac_ld is 0. The sample on adc_data is written into the word at mem_addr at the end of that cycle, with the upper bits of the word set to zero.
- R3: A record pass presents mem_addr values 0, 1, 2, ... up to 2^ADDR_W-1. It handles one address per cycle, and the first record cycle follows the accepted request by one clock.
- R4: In every play read cycle, mem_en is 1, mem_rw is 0, and adc_drive, adc_ld and dac_ld are 0.
- R5: dac_ld is 1 exactly in the cycle after each play read, with the same mem_addr held. In that cycle dac_data equals the sample stored at that address.
- R6: A play pass visits addresses 0 up to 2^ADDR_W-1 in ascending order, using two cycles per address.
- R7: After the cycle that handles the last address (2^ADDR_W-1), done is 1 for exactly one cycle with all strobes 0. The controller is in idle in the following cycle.
- R8: A request is accepted only in idle. start_rec or start_play raised during a pass has no effect on the addresses or the strobes of that pass.
- R9: If start_rec and start_play are both 1 in the same idle cycle, a record pass starts.
- R10: A play pass that follows a record pass delivers on dac_data the recorded samples in the order they were captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_rec | input | 1 | Request a record pass (sampled in idle) |
| start_play | input | 1 | Request a play pass (sampled in idle) |
| adc_data | input | SAMPLE_W | Sample presented by the input converter |
| adc_ld | output | 1 | Strobe asking the input converter for a sample |
| adc_drive | output | 1 | Enables the input buffer onto the shared bus |
| dac_ld | output | 1 | Load strobe for the output converter |
| dac_data | output | SAMPLE_W | Low bits of the shared bus, valid for the output converter when dac_ld is 1 |
| done | output | 1 | One-cycle pulse at the end of a pass |
| mem_addr | output | ADDR_W | Memory word address |
| mem_rw | output | 1 | 1 = write, 0 = read |
| mem_en | output | 1 | Memory enable |

## Verification
The bench builds the block with its defaults: ADDR_W=12, DATA_W=16 and SAMPLE_W=12, so every pass covers all 4096 words. At this size the step from address 4094 to 4095 is exercised, along with the end of each pass and the done pulse that follows it, exactly at the full-memory boundary. Three record/play rounds use seeded random samples. Directed all-zeros and all-ones values sit at the first and last words, so any bit stuck in the 12-bit sample path or in the address wrap is exposed. A reset in the middle of a pass and requests raised during busy passes complete the stimulus.

// File: rtl/sample_ram.sv
module sample_ram #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rw,
  input  logic              en,
  inout  wire  [DATA_W-1:0] data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata;

  always_ff @(posedge clk) begin
    if (en && rw) mem[addr] <= data;
    if (en && !rw) rdata <= mem[addr];
  end

  assign data = (en && !rw) ? rdata : 'z;
endmodule

// File: rtl/audio_recorder.sv
module audio_recorder #(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 16,
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_rec,
  input  logic                start_play,
  input  logic [SAMPLE_W-1:0] adc_data,
  output logic                adc_ld,
  output logic                adc_drive,
  output logic                dac_ld,
  output logic [SAMPLE_W-1:0] dac_data,
  output logic                done,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_rw,
  output logic                mem_en
);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};
  localparam int PAD = DATA_W - SAMPLE_W;

  typedef enum logic [2:0] {S_IDLE, S_REC, S_RD, S_LD, S_DONE} state_t;

  state_t            state;
  logic [ADDR_W-1:0] a;
  tri   [DATA_W-1:0] bus;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      a     <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start_rec) begin
            state <= S_REC;
            a     <= '0;
          end else if (start_play) begin
            state <= S_RD;
            a     <= '0;
          end
        end
        S_REC: begin
          if (a == LAST) state <= S_DONE;
          else a <= a + 1'b1;
        end
        S_RD: state <= S_LD;
        S_LD: begin
          if (a == LAST) state <= S_DONE;
          else begin
            a     <= a + 1'b1;
            state <= S_RD;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign adc_ld    = (state == S_REC);
  assign adc_drive = (state == S_REC);
  assign mem_rw    = (state == S_REC);
  assign mem_en    = (state == S_REC) || (state == S_RD) || (state == S_LD);
  assign dac_ld    = (state == S_LD);
  assign done      = (state == S_DONE);
  assign mem_addr  = a;

  assign bus      = adc_drive ? {{PAD{1'b0}}, adc_data} : 'z;
  assign dac_data = bus[SAMPLE_W-1:0];

  sample_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk  (clk),
    .addr (mem_addr),
    .rw   (mem_rw),
    .en   (mem_en),
    .data (bus)
  );

  a_r1_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({adc_ld, dac_ld, done}));

  a_r2_rec_strobes: assert property (@(posedge clk) disable iff (rst)
    mem_rw |-> (mem_en && adc_ld && adc_drive && !dac_ld));

  a_r3_rec_step: assert property (@(posedge clk) disable iff (rst)
    (mem_rw && $past(mem_rw)) |-> (mem_addr == $past(mem_addr) + 1'b1));

  a_r4_play_no_buf: assert property (@(posedge clk) disable iff (rst)
    (mem_en && !mem_rw) |-> (!adc_drive && !adc_ld));

  a_r5_dac_after_read: assert property (@(posedge clk) disable iff (rst)
    dac_ld |-> ($past(mem_en && !mem_rw && !dac_ld) && $stable(mem_addr)));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !mem_en));
endmodule

// File: tb/audio_recorder_tb.sv
module audio_recorder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 16;
  localparam int SAMPLE_W = 12;
  localparam int DEPTH = 1 << ADDR_W;

  logic clk = 0;
  logic rst = 1;
  logic start_rec = 0, start_play = 0;
  logic [SAMPLE_W-1:0] adc_data = '0;
  logic adc_ld, adc_drive, dac_ld, done, mem_rw, mem_en;
  logic [SAMPLE_W-1:0] dac_data;
  logic [ADDR_W-1:0] mem_addr;

  int vectors = 0;
  int fails = 0;
  logic [SAMPLE_W-1:0] expd [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_recorder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SAMPLE_W(SAMPLE_W)) u_dut (
    .clk(clk), .rst(rst), .start_rec(start_rec), .start_play(start_play),
    .adc_data(adc_data), .adc_ld(adc_ld), .adc_drive(adc_drive), .dac_ld(dac_ld),
    .dac_data(dac_data), .done(done), .mem_addr(mem_addr), .mem_rw(mem_rw),
    .mem_en(mem_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [5:0] strobes();
    return {adc_ld, adc_drive, dac_ld, done, mem_en, mem_rw};
  endfunction

  function automatic logic [SAMPLE_W-1:0] pick(input int round, input int i);
    if (i == 0) return (round == 0) ? '0 : '1;
    if (i == DEPTH-1) return (round == 0) ? '1 : '0;
    return SAMPLE_W'($urandom);
  endfunction

  task automatic check_idle(input string req);
    chk(strobes() == 6'b0, req, int'(strobes()), 0);
  endtask

  task automatic record_pass(input int round, input bit both);
    for (int i = 0; i < DEPTH; i++) expd[i] = pick(round, i);
    start_rec = 1;
    start_play = both;
    @(negedge clk);
    start_rec = 0;
    start_play = 0;
    if (both) chk(mem_rw == 1'b1, "R9", int'(mem_rw), 1);
    for (int i = 0; i < DEPTH; i++) begin
      adc_data = expd[i];
      if (i == 100) start_play = 1;
      if (i == 101) start_play = 0;
      chk(strobes() == 6'b110011, "R2", int'(strobes()), 'b110011);
      chk(mem_addr == ADDR_W'(i), (i > 100 && i < 103) ? "R8" : "R3", int'(mem_addr), i);
      @(negedge clk);
    end
    chk(done == 1'b1 && strobes() == 6'b000100, "R7", int'(strobes()), 'b000100);
    @(negedge clk);
    check_idle("R7");
  endtask

  task automatic play_pass();
    start_play = 1;
    @(negedge clk);
    start_play = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (i == 50) start_rec = 1;
      chk(strobes() == 6'b000010, "R4", int'(strobes()), 'b000010);
      chk(mem_addr == ADDR_W'(i), "R6", int'(mem_addr), i);
      @(negedge clk);
      start_rec = 0;
      chk(dac_ld == 1'b1 && mem_addr == ADDR_W'(i), (i == 50) ? "R8" : "R5",
          int'({dac_ld, mem_addr}), int'({1'b1, ADDR_W'(i)}));
      chk(dac_data == expd[i], "R10", int'(dac_data), int'(expd[i]));
      @(negedge clk);
    end
    chk(done == 1'b1 && strobes() == 6'b000100, "R7", int'(strobes()), 'b000100);
    @(negedge clk);
    check_idle("R7");
  endtask

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    rst = 0;
    check_idle("R1");
    @(negedge clk);
    check_idle("R1");

    record_pass(0, 1'b0);
    play_pass();
    record_pass(1, 1'b1);
    play_pass();
    record_pass(2, 1'b0);
    play_pass();

    start_play = 1;
    @(negedge clk);
    start_play = 0;
    repeat (7) @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    check_idle("R1");
    @(negedge clk);
    check_idle("R1");
    play_pass();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule